// File: doc/BRIEF.md
# Set/Clear GPIO Bank Controller

This block is a register-mapped general-purpose I/O controller that serves several banks of 32 pins each. Software never writes pin state directly. It changes direction and output value by writing ones into dedicated set and clear strobe registers. It learns the state of the pins by reading two status registers, one for direction and one for the synchronized pad level. Registers of the same kind sit next to one another for all banks, with a 4-byte step between banks. Registers of different kinds do not share an address group.

A global pin number `p` belongs to bank `p / 32` at bit `p % 32`. On the pad side the block drives one output value and one output enable for each pin. It also samples every pad input through a synchronizer chain, so the level can be read back whatever the pin's direction. The register port is a plain single-cycle bus: a byte address, a write enable and write data. Read data is a combinational function of the address.

Top module: `sc_gpio_ctrl`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all 0), every output value is 0 (`pad_out` all 0), and every direction status register reads 0.
- R2: Byte offsets of bank 0 are: level status 0x00, direction status 0x0C, output set 0x18, output clear 0x24, direction set 0x54, direction clear 0x60. Bank n of a kind is at that offset plus 4·n, for n below NUM_BANKS (3 by default, and at most 3). Bank n, bit k controls global pin 32·n+k.
- R3: A write to a direction-set register makes each pin whose data bit is 1 an output (`pad_oe` 1). Pins whose data bit is 0 keep their direction. The direction status register reads the current enables, bit k for pin k of the bank.
- R4: A write to a direction-clear register makes each pin whose data bit is 1 an input. Pins whose data bit is 0 keep their direction.
- R5: A write to an output-set register drives `pad_out` high for each pin whose data bit is 1. A write to an output-clear register drives it low for each such pin. Pins whose data bit is 0 keep their value.
- R6: An output value written while the pin is an input is held. It appears on the pin unchanged once the pin becomes an output.
- R7: All four set and clear registers read as 0, whatever has been written to them.
- R8: The level status register returns `pad_in` through a two-flop synchronizer for every pin, including pins driven as outputs. A change made before a rising edge is not visible after that edge and is visible after the following one.
- R9: Writes to status registers, to unaligned addresses, to bank indices at or above NUM_BANKS and to unmapped gaps change no state. Reads of unmapped addresses return 0.
- R10: A state change lands on the rising edge at which the write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32·NUM_BANKS (96) | Raw pad input levels |
| pad_out | output | 32·NUM_BANKS (96) | Output value per pin |
| pad_oe | output | 32·NUM_BANKS (96) | Output enable per pin, 1 = output |

## Verification
The hardest case to reach is the one where the set and clear registers carry no state software can read. The output value exists only on `pad_out`, and a value written to an input pin shows no sign until the direction changes. The stimulus therefore writes an output value into an input pin and checks that `pad_oe` stays low while `pad_out` already holds the value. It then sets the direction and checks both pins. Synchronizer latency is pinned by changing `pad_in` at a falling edge and reading the level register after one rising edge and again after two. The pins tested there include pins configured as outputs.

// File: rtl/sc_gpio_pkg.sv
`timescale 1ns/1ps
package sc_gpio_pkg;

  localparam int unsigned PINS_PER_BANK = 32;
  localparam int unsigned BANK_STRIDE   = 4;

  // Group base offsets; the bank index is added in 4-byte steps
  localparam int unsigned OFS_LEVEL   = 32'h00;
  localparam int unsigned OFS_DIR     = 32'h0C;
  localparam int unsigned OFS_OUT_SET = 32'h18;
  localparam int unsigned OFS_OUT_CLR = 32'h24;
  localparam int unsigned OFS_DIR_SET = 32'h54;
  localparam int unsigned OFS_DIR_CLR = 32'h60;

  typedef enum logic [2:0] {
    RK_NONE    = 3'd0,
    RK_LEVEL   = 3'd1,
    RK_DIR     = 3'd2,
    RK_OUT_SET = 3'd3,
    RK_OUT_CLR = 3'd4,
    RK_DIR_SET = 3'd5,
    RK_DIR_CLR = 3'd6
  } reg_kind_e;

  function automatic logic in_group(input int unsigned off, input int unsigned base,
                                    input int unsigned nb);
    return (off >= base) && (off < base + BANK_STRIDE * nb) && ((off % BANK_STRIDE) == 0);
  endfunction

  function automatic reg_kind_e kind_of(input int unsigned off, input int unsigned nb);
    if (in_group(off, OFS_LEVEL, nb))   return RK_LEVEL;
    if (in_group(off, OFS_DIR, nb))     return RK_DIR;
    if (in_group(off, OFS_OUT_SET, nb)) return RK_OUT_SET;
    if (in_group(off, OFS_OUT_CLR, nb)) return RK_OUT_CLR;
    if (in_group(off, OFS_DIR_SET, nb)) return RK_DIR_SET;
    if (in_group(off, OFS_DIR_CLR, nb)) return RK_DIR_CLR;
    return RK_NONE;
  endfunction

  function automatic int unsigned base_of(input reg_kind_e k);
    case (k)
      RK_LEVEL:   return OFS_LEVEL;
      RK_DIR:     return OFS_DIR;
      RK_OUT_SET: return OFS_OUT_SET;
      RK_OUT_CLR: return OFS_OUT_CLR;
      RK_DIR_SET: return OFS_DIR_SET;
      RK_DIR_CLR: return OFS_DIR_CLR;
      default:    return 0;
    endcase
  endfunction

  function automatic int unsigned bank_of(input int unsigned off, input reg_kind_e k);
    if (k == RK_NONE) return 0;
    return (off - base_of(k)) / BANK_STRIDE;
  endfunction

  // Global pin number split
  function automatic int unsigned pin_bank(input int unsigned pin);
    return pin / PINS_PER_BANK;
  endfunction

  function automatic int unsigned pin_bit(input int unsigned pin);
    return pin % PINS_PER_BANK;
  endfunction

endpackage

// File: rtl/sc_gpio_sync.sv
`timescale 1ns/1ps
module sc_gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_out = stg[STAGES-1];

endmodule

// File: rtl/sc_gpio_decode.sv
`timescale 1ns/1ps
module sc_gpio_decode
  import sc_gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned NPINS    = NUM_BANKS * PINS_PER_BANK
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output reg_kind_e         kind,
  output logic [31:0]       bank_idx,
  output logic              strobe_rd,
  output logic [NPINS-1:0]  dir_set_m,
  output logic [NPINS-1:0]  dir_clr_m,
  output logic [NPINS-1:0]  out_set_m,
  output logic [NPINS-1:0]  out_clr_m
);

  always_comb begin
    kind     = kind_of(32'(bus_addr), NUM_BANKS);
    bank_idx = bank_of(32'(bus_addr), kind);
  end

  assign strobe_rd = (kind == RK_OUT_SET) || (kind == RK_OUT_CLR) ||
                     (kind == RK_DIR_SET) || (kind == RK_DIR_CLR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_we && (bank_idx == 32'(b));
    assign dir_set_m[b*PINS_PER_BANK +: PINS_PER_BANK] =
      (hit && kind == RK_DIR_SET) ? bus_wdata : '0;
    assign dir_clr_m[b*PINS_PER_BANK +: PINS_PER_BANK] =
      (hit && kind == RK_DIR_CLR) ? bus_wdata : '0;
    assign out_set_m[b*PINS_PER_BANK +: PINS_PER_BANK] =
      (hit && kind == RK_OUT_SET) ? bus_wdata : '0;
    assign out_clr_m[b*PINS_PER_BANK +: PINS_PER_BANK] =
      (hit && kind == RK_OUT_CLR) ? bus_wdata : '0;
  end

endmodule

// File: rtl/sc_gpio_bank.sv
`timescale 1ns/1ps
module sc_gpio_bank #(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dir_set,
  input  logic [WIDTH-1:0] dir_clr,
  input  logic [WIDTH-1:0] out_set,
  input  logic [WIDTH-1:0] out_clr,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] lvl_q
);

  // Clear takes priority if both strobes hit one bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      dir_q <= (dir_q | dir_set) & ~dir_clr;
      out_q <= (out_q | out_set) & ~out_clr;
    end
  end

  sc_gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (pad_in),
    .q_out(lvl_q)
  );

endmodule

// File: rtl/sc_gpio_ctrl.sv
`timescale 1ns/1ps
module sc_gpio_ctrl
  import sc_gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 3,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NPINS      = NUM_BANKS * PINS_PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);

  reg_kind_e          kind;
  logic [31:0]        bank_idx;
  logic               strobe_rd;
  logic [NPINS-1:0]   dir_set_m, dir_clr_m, out_set_m, out_clr_m;
  logic [NPINS-1:0]   dir_all, out_all, lvl_all;

  sc_gpio_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) dec_i (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .kind     (kind),
    .bank_idx (bank_idx),
    .strobe_rd(strobe_rd),
    .dir_set_m(dir_set_m),
    .dir_clr_m(dir_clr_m),
    .out_set_m(out_set_m),
    .out_clr_m(out_clr_m)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sc_gpio_bank #(.WIDTH(PINS_PER_BANK), .SYNC_STAGES(SYNC_STAGES)) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .dir_set(dir_set_m[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .dir_clr(dir_clr_m[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .out_set(out_set_m[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .out_clr(out_clr_m[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pad_in (pad_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .dir_q  (dir_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .out_q  (out_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .lvl_q  (lvl_all[b*PINS_PER_BANK +: PINS_PER_BANK])
    );
  end

  assign pad_oe  = dir_all;
  assign pad_out = out_all;

  // Read path: only the two status kinds return data
  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (bank_idx == 32'(b)) begin
        if (kind == RK_LEVEL) bus_rdata = lvl_all[b*PINS_PER_BANK +: PINS_PER_BANK];
        if (kind == RK_DIR)   bus_rdata = dir_all[b*PINS_PER_BANK +: PINS_PER_BANK];
      end
    end
  end

endmodule

// File: rtl/sc_gpio_chk.sv
`timescale 1ns/1ps
module sc_gpio_chk #(
  parameter int unsigned NPINS = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] dir_set_m,
  input logic [NPINS-1:0] dir_clr_m,
  input logic [NPINS-1:0] out_set_m,
  input logic [NPINS-1:0] out_clr_m,
  input logic [NPINS-1:0] lvl_all,
  input logic             strobe_rd,
  input logic [31:0]      bus_rdata
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0) && (pad_out == '0)); // R1

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|dir_set_m, |dir_clr_m, |out_set_m, |out_clr_m})); // R2

  AST_DIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|dir_set_m) |=> ((pad_oe & $past(dir_set_m & ~dir_clr_m)) == $past(dir_set_m & ~dir_clr_m))); // R3

  AST_DIR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (|dir_clr_m) |=> ((pad_oe & $past(dir_clr_m)) == '0)); // R4

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_set_m == '0 && dir_clr_m == '0) |=> $stable(pad_oe)); // R9

  AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_set_m) |=> ((pad_out & $past(out_set_m & ~out_clr_m)) == $past(out_set_m & ~out_clr_m))); // R5

  AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_clr_m) |=> ((pad_out & $past(out_clr_m)) == '0)); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_set_m == '0 && out_clr_m == '0) |=> $stable(pad_out)); // R6

  AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rd |-> (bus_rdata == '0)); // R7

  AST_LEVEL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (lvl_all == $past(pad_in, 2))); // R8

endmodule

bind sc_gpio_ctrl sc_gpio_chk #(.NPINS(NPINS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pad_in   (pad_in),
  .pad_oe   (pad_oe),
  .pad_out  (pad_out),
  .dir_set_m(dir_set_m),
  .dir_clr_m(dir_clr_m),
  .out_set_m(out_set_m),
  .out_clr_m(out_clr_m),
  .lvl_all  (lvl_all),
  .strobe_rd(strobe_rd),
  .bus_rdata(bus_rdata)
);

// File: tb/sc_gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module sc_gpio_ctrl_tb_top;

  localparam int NB = 3;
  localparam int NP = NB * 32;
  localparam int NV = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  sc_gpio_ctrl #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [79:0] VEC [NV] = '{
    {8'h54, 32'hA5A5_0000, 8'h0C, 32'hA5A5_0000},
    {8'h58, 32'h0000_00FF, 8'h10, 32'h0000_00FF},
    {8'h5C, 32'h8000_0001, 8'h14, 32'h8000_0001},
    {8'h54, 32'h0000_0000, 8'h0C, 32'hA5A5_0000},
    {8'h60, 32'hA000_0000, 8'h0C, 32'h05A5_0000},
    {8'h64, 32'h0000_000F, 8'h10, 32'h0000_00F0},
    {8'h68, 32'hFFFF_FFFF, 8'h14, 32'h0000_0000},
    {8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h05A5_0000},
    {8'h6C, 32'hFFFF_FFFF, 8'h14, 32'h0000_0000},
    {8'h56, 32'hFFFF_FFFF, 8'h0C, 32'h05A5_0000},
    {8'h18, 32'h1234_5678, 8'h18, 32'h0000_0000},
    {8'h28, 32'h0000_FFFF, 8'h28, 32'h0000_0000},
    {8'h30, 32'h0000_00FF, 8'h30, 32'h0000_0000}
  };
  localparam string VTAG [NV] = '{
    "R3", "R2", "R2", "R3", "R4", "R4", "R4", "R9", "R9", "R9", "R7", "R7", "R9"
  };

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, NP'(bus_rdata), NP'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    rd("R1 dir0", 8'h0C, 32'h0);
    rd("R1 dir1", 8'h10, 32'h0);
    rd("R1 dir2", 8'h14, 32'h0);

    // Table walk (R2 R3 R4 R7 R9 R10)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VTAG[i], VEC[i][39:32], VEC[i][31:0]);
    end
    check("R3 pad_oe bank0", NP'(pad_oe[31:0]), NP'(32'h05A5_0000));
    check("R2 pad_oe bank1", NP'(pad_oe[63:32]), NP'(32'h0000_00F0));

    // R5 output set/clear through pad_out
    check("R5 out bank0", NP'(pad_out[31:0]), NP'(32'h1234_5678));
    wr(8'h1C, 32'h0000_FF00);
    check("R5 out set bank1", NP'(pad_out[63:32]), NP'(32'h0000_FF00));
    wr(8'h28, 32'h0000_0F00);
    check("R5 out clr bank1", NP'(pad_out[63:32]), NP'(32'h0000_F000));
    wr(8'h28, 32'h0000_0000);
    check("R5 zero bits", NP'(pad_out[63:32]), NP'(32'h0000_F000));

    // R6 value written while input, then direction turned to output (global pin 69)
    wr(8'h20, 32'h0000_0020);
    check("R6 value held", NP'(pad_out[95:64]), NP'(32'h0000_0020));
    check("R6 still input", NP'(pad_oe[95:64]), NP'(32'h0));
    wr(8'h5C, 32'h0000_0020);
    check("R6 now output", NP'(pad_oe[95:64]), NP'(32'h0000_0020));
    check("R6 value kept", NP'(pad_out[95:64]), NP'(32'h0000_0020));

    // R8 level readback latency, including output pins of bank 0
    @(negedge clk);
    pad_in = {32'hCAFE_0001, 32'h0F0F_0F0F, 32'h05A5_3C3C};
    @(posedge clk);
    @(negedge clk);
    rd("R8 one edge", 8'h00, 32'h0);
    @(posedge clk);
    @(negedge clk);
    rd("R8 level bank0", 8'h00, 32'h05A5_3C3C);
    rd("R8 level bank1", 8'h04, 32'h0F0F_0F0F);
    rd("R8 level bank2", 8'h08, 32'hCAFE_0001);

    // R9 write to level status has no effect on any pin
    wr(8'h00, 32'hFFFF_FFFF);
    check("R9 level write oe", NP'(pad_oe[31:0]), NP'(32'h05A5_0000));
    check("R9 level write out", NP'(pad_out[31:0]), NP'(32'h1234_5678));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule